// File: doc/BRIEF.md
# Split Translation-Range Selector

This block decides which of two translation-table descriptors governs a 64-bit input address: the low-region descriptor or the high-region descriptor. When the address falls between the two regions, it raises a translation fault instead. The decision uses four inputs: the address, a size field for each region (the count of upper address bits that must be zero for a region hit), and one top-byte-ignore enable per region. A table walker consumes the result before it fetches its first descriptor.

The logic is purely combinational. The address, the size fields and the enables arrive together, and the select, valid and fault outputs settle in the same cycle. Address bit 55 picks which top-byte-ignore enable applies. When that enable is set, the eight most significant address bits drop out of both region checks. A region whose size field is zero does not match by itself. Instead it covers every address the other region does not claim. The low region takes precedence at every step.

Top module: `range_split_sel`

## Requirements
- R1: Address bit 55 selects the top-byte-ignore enable. When bit 55 is 1, `hi_tbi_i` applies. When it is 0, `lo_tbi_i` applies. The chosen enable governs the checks of both regions.
- R2: With the chosen enable set, address bits 63..56 are excluded from the checks. The checked field for a region of size `t` is then bits 55 down to 64-`t`. With the enable clear, the field is bits 63 down to 64-`t`.
- R3: When `lo_tsz_i` is nonzero and the low region's checked field is all zero, the output is `region_sel_o`=0 (low), `valid_o`=1 and `fault_o`=0.
- R4: When R3 does not apply, `hi_tsz_i` is nonzero and the high region's checked field is all zero, the output is `region_sel_o`=1 (high) and `valid_o`=1.
- R5: When neither field check passes and `lo_tsz_i` is zero, the low region is selected (`region_sel_o`=0, `valid_o`=1). This includes the case where both sizes are zero.
- R6: When neither field check passes, `lo_tsz_i` is nonzero and `hi_tsz_i` is zero, the high region is selected (`region_sel_o`=1, `valid_o`=1).
- R7: When both sizes are nonzero and neither field check passes, the output is `fault_o`=1, `valid_o`=0 and `region_sel_o`=0.
- R8: Exactly one of `valid_o` and `fault_o` is 1 for every input combination.
- R9: When the top-byte-ignore enable is in force and a size is 8 or less, that region's checked field is empty. An empty field counts as all zero, so the region matches whenever its size is nonzero.
- R10: The outputs depend only on the present inputs. They are valid in the same cycle the inputs are applied, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 64 | Input address to classify |
| lo_tsz_i | input | 6 | Low-region size field (count of upper bits that must be zero) |
| hi_tsz_i | input | 6 | High-region size field |
| lo_tbi_i | input | 1 | Top-byte-ignore enable used when address bit 55 is 0 |
| hi_tbi_i | input | 1 | Top-byte-ignore enable used when address bit 55 is 1 |
| region_sel_o | output | 1 | 0 = low region, 1 = high region; 0 on a fault |
| valid_o | output | 1 | A region was selected |
| fault_o | output | 1 | Address lies in the gap between the regions |

## Verification
Two functions can decide the same cycle's result:
- the field match of a region;
- the catch-all of a zero-size region.

Their priority is the main risk. The bench sets one size to zero and makes the other region's field nonzero, so that only the catch-all can decide. It also sets one size to zero and makes the other region's field match, so the field match must win. It judges the select output against the ordering in R3 to R6.

The second overlap is between top-byte-ignore and the field check. An address with nonzero top-byte bits, together with an enable chosen by bit 55, must flip between a hit and a fault as only the enable on the other side of bit 55 changes.

// File: rtl/range_split_pkg.sv
package range_split_pkg;
  typedef enum logic {
    REG_LO = 1'b0,
    REG_HI = 1'b1
  } region_e;

  typedef struct packed {
    logic    hit;
    logic    tsz_zero;
  } region_chk_t;
endpackage

// File: rtl/rsel_tbi_pick.sv
module rsel_tbi_pick (
  input  logic sel_bit_i,
  input  logic lo_tbi_i,
  input  logic hi_tbi_i,
  output logic ign_o
);
  assign ign_o = sel_bit_i ? hi_tbi_i : lo_tbi_i;

  always_comb begin
    if (!$isunknown({sel_bit_i, lo_tbi_i, hi_tbi_i})) begin
      assert_tbi_src_R1: assert (sel_bit_i || (ign_o == lo_tbi_i))
        else $error("tbi source wrong for bit55=0");
    end
  end
endmodule

// File: rtl/rsel_region_match.sv
module rsel_region_match
  import range_split_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int TSZ_W    = 6,
  parameter int IGN_BITS = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TSZ_W-1:0]  tsz_i,
  input  logic              ign_i,
  output region_chk_t       chk_o
);
  localparam int TOP_IGN = ADDR_W - IGN_BITS;

  logic [ADDR_W-1:0] field_mask;
  int                lo_edge;
  int                hi_edge;

  always_comb begin
    lo_edge = ADDR_W - int'(tsz_i);
    hi_edge = ign_i ? TOP_IGN : ADDR_W;
    for (int i = 0; i < ADDR_W; i++) begin
      field_mask[i] = (i >= lo_edge) && (i < hi_edge);
    end
  end

  assign chk_o.tsz_zero = (tsz_i == '0);
  assign chk_o.hit      = !chk_o.tsz_zero && ((addr_i & field_mask) == '0);

  always_comb begin
    if (!$isunknown({addr_i, tsz_i, ign_i})) begin
      // zero size never matches on its own
      assert_zero_size_no_hit_R3: assert (!(chk_o.hit && (tsz_i == '0)))
        else $error("zero-size region reported a hit");
      // without ignore, a hit needs a clear top bit
      assert_top_bit_R2: assert (!(chk_o.hit && !ign_i && addr_i[ADDR_W-1]))
        else $error("hit with top bit set and no ignore");
      assert_empty_field_R9: assert (!(ign_i && (tsz_i != '0) &&
                                       (int'(tsz_i) <= IGN_BITS) && !chk_o.hit))
        else $error("empty field did not match");
    end
  end
endmodule

// File: rtl/rsel_arbiter.sv
module rsel_arbiter
  import range_split_pkg::*;
(
  input  region_chk_t lo_i,
  input  region_chk_t hi_i,
  output region_e     sel_o,
  output logic        valid_o,
  output logic        fault_o
);
  always_comb begin
    sel_o   = REG_LO;
    valid_o = 1'b1;
    fault_o = 1'b0;
    if (lo_i.hit) begin
      sel_o = REG_LO;
    end else if (hi_i.hit) begin
      sel_o = REG_HI;
    end else if (lo_i.tsz_zero) begin
      sel_o = REG_LO;
    end else if (hi_i.tsz_zero) begin
      sel_o = REG_HI;
    end else begin
      valid_o = 1'b0;
      fault_o = 1'b1;
    end
  end
endmodule

// File: rtl/range_split_sel.sv
module range_split_sel
  import range_split_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int TSZ_W    = 6,
  parameter int IGN_BITS = 8,
  parameter int SEL_BIT  = 55
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TSZ_W-1:0]  lo_tsz_i,
  input  logic [TSZ_W-1:0]  hi_tsz_i,
  input  logic              lo_tbi_i,
  input  logic              hi_tbi_i,
  output logic              region_sel_o,
  output logic              valid_o,
  output logic              fault_o
);
  localparam int NUM_REG = 2;

  logic              ign;
  logic [TSZ_W-1:0]  tsz_arr [NUM_REG];
  region_chk_t       chk_arr [NUM_REG];
  region_e           sel;

  assign tsz_arr[0] = lo_tsz_i;
  assign tsz_arr[1] = hi_tsz_i;

  rsel_tbi_pick u_tbi (
    .sel_bit_i (addr_i[SEL_BIT]),
    .lo_tbi_i  (lo_tbi_i),
    .hi_tbi_i  (hi_tbi_i),
    .ign_o     (ign)
  );

  for (genvar g = 0; g < NUM_REG; g++) begin : g_region
    rsel_region_match #(
      .ADDR_W   (ADDR_W),
      .TSZ_W    (TSZ_W),
      .IGN_BITS (IGN_BITS)
    ) u_match (
      .addr_i (addr_i),
      .tsz_i  (tsz_arr[g]),
      .ign_i  (ign),
      .chk_o  (chk_arr[g])
    );
  end

  rsel_arbiter u_arb (
    .lo_i    (chk_arr[0]),
    .hi_i    (chk_arr[1]),
    .sel_o   (sel),
    .valid_o (valid_o),
    .fault_o (fault_o)
  );

  assign region_sel_o = sel;

  always_comb begin
    if (!$isunknown({addr_i, lo_tsz_i, hi_tsz_i, lo_tbi_i, hi_tbi_i})) begin
      assert_one_status_R8: assert (valid_o ^ fault_o)
        else $error("valid and fault not exclusive");
      assert_fault_sizes_R7: assert (!fault_o || ((lo_tsz_i != '0) && (hi_tsz_i != '0)))
        else $error("fault with a catch-all region present");
      assert_fault_sel_low_R7: assert (!fault_o || !region_sel_o)
        else $error("select not low on fault");
      assert_low_wins_R3: assert (!chk_arr[0].hit || (valid_o && !region_sel_o))
        else $error("low hit not selected");
      assert_low_catchall_R5: assert (!((lo_tsz_i == '0) && !chk_arr[1].hit) ||
                                      (valid_o && !region_sel_o))
        else $error("low catch-all not selected");
      assert_high_pick_R4: assert (!(valid_o && region_sel_o) ||
                                   (!chk_arr[0].hit && (chk_arr[1].hit || hi_tsz_i == '0)))
        else $error("high chosen without cause");
    end
  end
endmodule

// File: tb/range_split_sel_tb_top.sv
`timescale 1ns/1ps
module range_split_sel_tb_top;
  logic        clk;
  logic        rst_ni;
  logic [63:0] addr;
  logic [5:0]  lo_tsz, hi_tsz;
  logic        lo_tbi, hi_tbi;
  logic        sel_o, valid_o, fault_o;

  typedef struct {
    logic  sel;
    logic  vld;
    logic  flt;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  range_split_sel dut_i (
    .addr_i       (addr),
    .lo_tsz_i     (lo_tsz),
    .hi_tsz_i     (hi_tsz),
    .lo_tbi_i     (lo_tbi),
    .hi_tbi_i     (hi_tbi),
    .region_sel_o (sel_o),
    .valid_o      (valid_o),
    .fault_o      (fault_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // field of upper bits must be zero; empty field counts as zero
  function automatic bit ref_hit(logic [63:0] a, int t, bit ign);
    int top;
    if (t == 0) return 0;
    top = ign ? 55 : 63;
    for (int b = 64 - t; b <= top; b++) if (a[b]) return 0;
    return 1;
  endfunction

  task automatic drive(logic [63:0] a, int lt, int ht, bit lb, bit hb, string req);
    exp_t e;
    bit   ign, lh, hh;
    @(posedge clk);
    #1;
    addr = a; lo_tsz = 6'(lt); hi_tsz = 6'(ht); lo_tbi = lb; hi_tbi = hb;
    ign = a[55] ? hb : lb;
    lh  = ref_hit(a, lt, ign);
    hh  = ref_hit(a, ht, ign);
    e.req = req;
    if (lh)           begin e.sel = 0; e.vld = 1; e.flt = 0; end
    else if (hh)      begin e.sel = 1; e.vld = 1; e.flt = 0; end
    else if (lt == 0) begin e.sel = 0; e.vld = 1; e.flt = 0; end
    else if (ht == 0) begin e.sel = 1; e.vld = 1; e.flt = 0; end
    else              begin e.sel = 0; e.vld = 0; e.flt = 1; end
    q.push_back(e);
  endtask

  // monitor: compare in the cycle the inputs were applied (R10)
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if ({sel_o, valid_o, fault_o} !== {e.sel, e.vld, e.flt}) begin
        n_bad++;
        $display("FAIL %s: sel/valid/fault actual %b%b%b expected %b%b%b",
                 e.req, sel_o, valid_o, fault_o, e.sel, e.vld, e.flt);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    rst_ni = 1'b0;
    addr = '0; lo_tsz = '0; hi_tsz = '0; lo_tbi = 0; hi_tbi = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    drive(64'h0, 0, 0, 0, 0, "R5 reset state both zero");
    drive(64'h0000_0000_0000_1234, 16, 16, 0, 0, "R3 low hit");
    drive(64'h00FF_0000_0000_0000, 16, 8, 0, 0, "R4 high hit after low miss");
    drive(64'h0001_0000_0000_0000, 16, 16, 0, 0, "R7 gap fault");
    drive(64'h8000_0000_0000_0000, 16, 0, 0, 0, "R6 high catch-all");
    drive(64'h8000_0000_0000_0000, 0, 16, 0, 0, "R5 low catch-all");
    drive(64'h0000_0000_0000_0040, 0, 16, 0, 0, "R4 high hit beats low catch-all");
    drive(64'h0000_0000_0000_0040, 16, 0, 0, 0, "R3 low hit beats high catch-all");
    drive(64'hAB00_0000_0000_1000, 16, 16, 1, 0, "R2 ignore top byte");
    drive(64'hAB00_0000_0000_1000, 16, 16, 0, 1, "R1 bit55=0 uses low enable");
    drive(64'hFF80_0000_0000_0000, 8, 8, 0, 1, "R1 bit55=1 uses high enable");
    drive(64'hFF80_0000_0000_0000, 8, 8, 1, 0, "R1 bit55=1 ignores low enable");
    drive(64'hFF00_0000_0000_0000, 4, 12, 1, 0, "R9 empty low field");
    drive(64'hFF10_0000_0000_0000, 12, 3, 1, 1, "R9 empty high field");
    drive(64'h0100_0000_0000_0000, 9, 9, 1, 1, "R2 bit56 ignored");
    drive(64'h0080_0000_0000_0000, 9, 9, 1, 1, "R7 bit55 still checked");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 63, 63, 1, 1, "R8 all ones fault");
    drive(64'h0000_0000_0000_0001, 63, 1, 0, 0, "R3 max size");

    lfsr = 64'hACE1_1234_5678_9ABD;
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      a = lfsr;
      case (lfsr[3:2])
        2'd0: a = a >> lfsr[9:4];
        2'd1: a = a & 64'h00FF_FFFF_FFFF_FFFF;
        2'd2: a = a & ~(64'hFFFF << lfsr[15:10]);
        default: ;
      endcase
      drive(a, int'(lfsr[21:16]) & (lfsr[40] ? 63 : 15),
               int'(lfsr[27:22]) & (lfsr[41] ? 63 : 15),
               lfsr[30], lfsr[31], "R10 mixed random");
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule